// File: doc/BRIEF.md
# PHY Register Access Bridge

This block sits between a host bus and a bank of 16-bit PHY configuration registers. The host sees a single 32-bit control word. Writing that word starts one access to the bank. The access is a store when the command bit is set and a fetch when it is clear. While the access runs, the bridge shows a busy bit in the same word. Once busy drops, a fetch has placed the register contents in the upper half of the word.

The bank holds 48 entries of 16 bits each. An access always takes a fixed number of clock cycles, set by a parameter, so host software can poll the busy bit with a coarse timer. Addresses past the end of the bank are accepted and take the same busy time. A fetch from such an address returns zero and a store to one changes nothing. Any control-word write that arrives while an access is still running is dropped.

Top module: `phy_regbridge`

## Requirements
- R1: After reset the control word reads 0x00000000 and every bank entry holds 0.
- R2: Control word layout: bit 0 is the command (1 = store, 0 = fetch), bits [15:8] the register address, bits [31:16] the data, bit 7 the busy flag; bits [6:1] always read 0.
- R3: A control-word write while idle sets busy in the next cycle and latches the command bit and address into the word.
- R4: Busy stays set for exactly BUSY_CYCLES consecutive cycles (default 8) per access.
- R5: A store writes its 16-bit data into the addressed entry when busy clears. A fetch loads the entry into bits [31:16] in the same cycle that busy clears.
- R6: All 48 entries (addresses 0x00 to 0x2F) are independent: a store to one entry leaves every other entry unchanged.
- R7: An address of 0x30 or above still takes the full busy time. A fetch from it returns 0 in bits [31:16], and a store to it changes no entry.
- R8: A control-word write that arrives while busy is set is ignored. The running access finishes with its own command, address and data, and the dropped word's store never reaches the bank.
- R9: While idle with no host write, the control word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe for the control word |
| host_wdata | input | 32 | Control word written by the host |
| host_rdata | output | 32 | Current control word as read by the host |

## Verification
The checker watches four things on every cycle: the busy pulse width, the latching of a command on an idle write, the dropping of writes made while busy, and zero return for out-of-range fetches. It also checks that the idle word stays stable and that the reserved bits stay zero. Other properties need the bench's scenarios, which compare against a reference model of the bank. These are that stored data actually comes back through a later fetch, that entries do not interfere with one another, that a dropped store leaves no trace in the bank, and that an out-of-range store corrupts nothing.

// File: rtl/phy_regbridge_pkg.sv
package phy_regbridge_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;

    localparam int CMD_BIT    = 0;
    localparam int BUSY_BIT   = 7;
    localparam int ADDR_LSB   = 8;
    localparam int DATA_LSB   = 16;

    typedef struct packed {
        logic              store;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_t;

    function automatic logic [WORD_W-1:0] pack_word(input cmd_t c, input logic busy);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CMD_BIT]                       = c.store;
        w[BUSY_BIT]                      = busy;
        w[ADDR_LSB +: ADDR_W]            = c.addr;
        w[DATA_LSB +: DATA_W]            = c.data;
        return w;
    endfunction

endpackage

// File: rtl/phy_regbridge_decode.sv
module phy_regbridge_decode
    import phy_regbridge_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output cmd_t              cmd_o
);

    always_comb begin
        cmd_o.store = word_i[CMD_BIT];
        cmd_o.addr  = word_i[ADDR_LSB +: ADDR_W];
        cmd_o.data  = word_i[DATA_LSB +: DATA_W];
    end

endmodule

// File: rtl/phy_regbridge_timer.sv
module phy_regbridge_timer #(
    parameter int BUSY_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);

    localparam int CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i && !st_q.busy) begin
            st_d.busy = 1'b1;
            st_d.cnt  = LOAD;
        end else if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.busy && (st_q.cnt == '0);

endmodule

// File: rtl/phy_regbridge_bank.sv
module phy_regbridge_bank
    import phy_regbridge_pkg::*;
#(
    parameter int DEPTH = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              in_range_o
);

    logic [DATA_W-1:0] ent_q [DEPTH];
    logic [DATA_W-1:0] ent_d [DEPTH];

    assign in_range_o = (int'(addr_i) < DEPTH);

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_comb begin
            ent_d[g] = ent_q[g];
            if (we_i && (int'(addr_i) == g)) begin
                ent_d[g] = wdata_i;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[g] <= '0;
            end else begin
                ent_q[g] <= ent_d[g];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (int'(addr_i) == i) begin
                rdata_o = ent_q[i];
            end
        end
    end

endmodule

// File: rtl/phy_regbridge.sv
module phy_regbridge
    import phy_regbridge_pkg::*;
#(
    parameter int BUSY_CYCLES = 8,
    parameter int DEPTH       = 48
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr_en,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata
);

    cmd_t        host_cmd;
    logic        busy;
    logic        done;
    logic        launch;
    logic        bank_we;
    logic        bank_in_range;
    logic [DATA_W-1:0] bank_rdata;

    typedef struct packed {
        cmd_t cur;
    } br_t;

    br_t st_d, st_q;

    phy_regbridge_decode u_decode (
        .word_i (host_wdata),
        .cmd_o  (host_cmd)
    );

    phy_regbridge_timer #(
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (launch),
        .busy_o  (busy),
        .done_o  (done)
    );

    phy_regbridge_bank #(
        .DEPTH (DEPTH)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (bank_we),
        .addr_i     (st_q.cur.addr),
        .wdata_i    (st_q.cur.data),
        .rdata_o    (bank_rdata),
        .in_range_o (bank_in_range)
    );

    assign launch  = host_wr_en && !busy;
    assign bank_we = done && st_q.cur.store && bank_in_range;

    always_comb begin
        st_d = st_q;
        if (launch) begin
            st_d.cur = host_cmd;
        end else if (done && !st_q.cur.store) begin
            st_d.cur.data = bank_in_range ? bank_rdata : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_rdata = pack_word(st_q.cur, busy);

endmodule

// File: rtl/phy_regbridge_chk.sv
module phy_regbridge_chk #(
    parameter int BUSY_CYCLES = 8,
    parameter int DEPTH       = 48
) (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr_en,
    input logic [31:0] host_wdata,
    input logic [31:0] host_rdata
);

    logic        busy;
    logic [31:0] run_q;

    assign busy = host_rdata[7];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy) begin
            run_q <= run_q + 1;
        end else begin
            run_q <= '0;
        end
    end

    // R4
    a_r4_busy_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == 32'(BUSY_CYCLES)));

    // R3
    a_r3_launch_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && !busy) |=> (busy && host_rdata[15:8] == $past(host_wdata[15:8])
                                   && host_rdata[0] == $past(host_wdata[0])));

    // R8
    a_r8_drop_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && busy) |=> ($stable(host_rdata[15:8]) && $stable(host_rdata[0])));

    // R7
    a_r7_oob_fetch_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !host_rdata[0] && (int'(host_rdata[15:8]) >= DEPTH))
            |-> (host_rdata[31:16] == 16'h0));

    // R9
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !host_wr_en) |=> $stable(host_rdata));

    // R2
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[6:1] == 6'b0);

endmodule

bind phy_regbridge phy_regbridge_chk #(
    .BUSY_CYCLES (BUSY_CYCLES),
    .DEPTH       (DEPTH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr_en (host_wr_en),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata)
);

// File: tb/phy_regbridge_bench.sv
module phy_regbridge_bench;

    localparam int N     = 8;
    localparam int DEPTH = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done_flag = 0;

    logic [15:0] model [DEPTH];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    phy_regbridge #(.BUSY_CYCLES(N), .DEPTH(DEPTH)) u_phy_regbridge (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr_en (host_wr_en),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // monitor: count busy cycles and compare completed word
    int  busy_run = 0;
    bit  prev_busy = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (host_rdata[7]) busy_run++;
            if (prev_busy && !host_rdata[7]) begin
                check("R4 busy width", 32'(busy_run), 32'(N));
                if (exp_q.size() > 0) begin
                    string t;
                    t = tag_q.pop_front();
                    check(t, host_rdata, exp_q.pop_front());
                end else begin
                    check("R5 unexpected completion", host_rdata, 32'hdead_beef);
                end
                busy_run = 0;
            end
            prev_busy = host_rdata[7];
        end
    end

    task automatic launch(input bit st, input logic [7:0] a, input logic [15:0] d,
                          input string t, input bit intrude);
        logic [15:0] ed;
        while (host_rdata[7]) @(negedge clk);
        if (st) begin
            ed = d;
            if (int'(a) < DEPTH) model[a] = d;
        end else begin
            ed = (int'(a) < DEPTH) ? model[a] : 16'h0;
        end
        exp_q.push_back({ed, a, 7'b0, st});
        tag_q.push_back(t);
        host_wdata = {d, a, 7'b0, st};
        host_wr_en = 1'b1;
        @(negedge clk);
        host_wr_en = 1'b0;
        check("R3 launch", {host_rdata[15:7], host_rdata[0]}, {a, 1'b1, st});
        if (intrude) begin
            // R8: a store to entry 5 while busy must be dropped
            host_wdata = {16'h9999, 8'h05, 7'b0, 1'b1};
            host_wr_en = 1'b1;
            @(negedge clk);
            host_wr_en = 1'b0;
        end
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset word", host_rdata, 32'h0);
        launch(0, 8'h2A, 16'h0, "R1 reset entry", 0);

        launch(1, 8'h00, 16'hA5C3, "R5 store", 0);
        launch(1, 8'h2F, 16'h1234, "R5 store top", 0);
        launch(1, 8'h09, 16'h525C, "R6 store", 0);
        launch(0, 8'h00, 16'hFFFF, "R5 fetch", 0);
        launch(0, 8'h2F, 16'h0, "R6 fetch top", 0);
        launch(0, 8'h09, 16'h0, "R6 fetch", 0);
        launch(0, 8'h01, 16'h0, "R6 neighbour", 0);

        launch(1, 8'h30, 16'hBEEF, "R7 oob store", 0);
        launch(0, 8'h30, 16'h7777, "R7 oob fetch", 0);
        launch(0, 8'hFF, 16'h0, "R7 oob fetch ff", 0);
        for (int i = 0; i < DEPTH; i++) begin
            launch(0, 8'(i), 16'h0, "R7 no corruption", 0);
        end

        launch(1, 8'h05, 16'h4444, "R8 first store", 0);
        launch(0, 8'h09, 16'h0, "R8 running access", 1);
        launch(0, 8'h05, 16'h0, "R8 dropped store", 0);

        // R9: word holds while idle
        begin
            logic [31:0] snap;
            snap = host_rdata;
            repeat (5) @(negedge clk);
            check("R9 idle hold", host_rdata, snap);
            check("R2 reserved bits", 32'(host_rdata[6:1]), 32'h0);
        end
        done_flag = 1;
    end

    initial begin
        while (!done_flag && cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done_flag) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule